// File: doc/BRIEF.md
# Byte Block Copy Engine

This block is a small sequencer that copies a run of bytes from one place in memory to another, in the manner of a processor's block-move instruction. A single start pulse loads a 24-bit source pointer, a 24-bit destination pointer and a byte count. The engine then moves one byte per step until the count reaches zero. A mode input chooses whether the count is taken as 8 or 16 bits wide.

The engine drives a synchronous single-port memory. The memory has one cycle of read latency. Each byte is moved by a read cycle at the source address, followed by a write cycle at the destination address. The pointers are held as 32-bit values whose top 8 bits are always zero. When the run finishes, the final pointers and the count stay on the outputs, so a caller can continue from where the copy stopped.

Top module: `byte_copy_engine`

## Requirements
- R1: A start with an effective count of zero makes no memory access; busy and done are both high in the single cycle after start, and the engine is idle in the cycle after that.
- R2: Each byte uses two cycles. In the first, mem_rd is high and mem_addr equals the source pointer. In the next, mem_wr is high, mem_addr equals the destination pointer, and mem_wdata carries the byte returned by that read. mem_rd and mem_wr are never high together.
- R3: After each write, both pointers increase by one, wrapping from 0xFFFFFF to 0x000000. Bits 31:24 of both pointer outputs are always zero.
- R4: After each write, the count decreases by one. The transfer stops when the count reaches zero, so exactly the effective count of bytes is moved.
- R5: When wide_mode is 0, only bits 7:0 of count_in are used. For example, 0x0103 moves 3 bytes and 0x0100 moves none.
- R6: When wide_mode is 1, all 16 bits of count_in are used. For example, 300 moves 300 bytes.
- R7: While idle and start is low, the pointer and count outputs hold their values. After a copy of N bytes they read source+N, destination+N (both wrapped) and a count of 0.
- R8: A start that arrives while busy is high is ignored. The transfer in progress continues unchanged, and the new values are never loaded.
- R9: Busy rises in the cycle after an accepted start and stays high through the done cycle, which is 2N+1 cycles for N bytes. Done is a one-cycle pulse.
- R10: After reset, busy, done, mem_rd and mem_wr are low, and the pointer and count outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| src_start | input | 24 | Source start address |
| dst_start | input | 24 | Destination start address |
| count_in | input | 16 | Byte count |
| wide_mode | input | 1 | 1: 16-bit count, 0: 8-bit count |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | 32 | Current source pointer, zero-extended |
| dst_ptr | output | 32 | Current destination pointer, zero-extended |
| count_left | output | 16 | Remaining byte count |

## Verification
The assertions check several behaviours on every cycle:
- every read is followed by a write, and the two strobes never overlap;
- each write advances both pointers by one with 24-bit wrap and lowers the count by one;
- the counter never steps below zero;
- done lasts one cycle;
- the pointer and count outputs are frozen while the engine is idle.

Only the bench scenarios can show the rest. These are that the right number of bytes is moved for each count mode, that the destination receives the source's bytes and nothing past them, that a zero count makes no access, and that a start arriving mid-transfer leaves the run and the memory untouched.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FINISH = 2'd3
  } bce_state_t;
endpackage

// File: rtl/bce_ptr_reg.sv
module bce_ptr_reg #(
  parameter int AW = 24,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] ptr_out
);
  localparam int PAD = PW - AW;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (step) begin
      ptr_q <= ptr_q + {{(AW-1){1'b0}}, 1'b1};
    end
  end

  assign ptr_out = {{PAD{1'b0}}, ptr_q};

  // R3
  load_step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && step));
endmodule

// File: rtl/bce_count_reg.sv
module bce_count_reg #(
  parameter int CW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          wide,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          load_zero,
  output logic          last
);
  logic [CW-1:0] eff_val;

  generate
    if (CW > NW) begin : g_mask
      assign eff_val = wide ? load_val : {{(CW-NW){1'b0}}, load_val[NW-1:0]};
    end else begin : g_nomask
      assign eff_val = load_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= eff_val;
    end else if (step) begin
      count <= count - {{(CW-1){1'b0}}, 1'b1};
    end
  end

  assign load_zero = (eff_val == '0);
  assign last      = (count == {{(CW-1){1'b0}}, 1'b1});

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (count != '0));
endmodule

// File: rtl/bce_fsm.sv
module bce_fsm
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       load_zero,
  input  logic       last,
  output bce_state_t state,
  output logic       load,
  output logic       step
);
  bce_state_t nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    step = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          nxt  = load_zero ? ST_FINISH : ST_READ;
        end
      end
      ST_READ:  nxt = ST_WRITE;
      ST_WRITE: begin
        step = 1'b1;
        nxt  = last ? ST_FINISH : ST_READ;
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R9
  finish_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISH) |=> (state == ST_IDLE));
  // R8
  load_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (state == ST_IDLE));
endmodule

// File: rtl/byte_copy_engine.sv
module byte_copy_engine
  import bce_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 32,
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic [CW-1:0] count_in,
  input  logic          wide_mode,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] src_ptr,
  output logic [PW-1:0] dst_ptr,
  output logic [CW-1:0] count_left
);
  bce_state_t state;
  logic load, step, load_zero, last;

  bce_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .load_zero(load_zero),
    .last(last), .state(state), .load(load), .step(step)
  );

  bce_ptr_reg #(.AW(AW), .PW(PW)) u_src (
    .clk(clk), .rst(rst), .load(load), .load_val(src_start),
    .step(step), .ptr_out(src_ptr)
  );

  bce_ptr_reg #(.AW(AW), .PW(PW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .load_val(dst_start),
    .step(step), .ptr_out(dst_ptr)
  );

  bce_count_reg #(.CW(CW), .NW(NW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .wide(wide_mode),
    .load_val(count_in), .step(step), .count(count_left),
    .load_zero(load_zero), .last(last)
  );

  assign mem_rd    = (state == ST_READ);
  assign mem_wr    = (state == ST_WRITE);
  assign mem_addr  = (state == ST_WRITE) ? dst_ptr[AW-1:0] : src_ptr[AW-1:0];
  assign mem_wdata = mem_rdata;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> mem_wr);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R3
  src_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (src_ptr[AW-1:0] == AW'($past(src_ptr[AW-1:0]) + 1'b1)));
  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (dst_ptr[AW-1:0] == AW'($past(dst_ptr[AW-1:0]) + 1'b1)));
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (count_left == CW'($past(count_left) - 1'b1)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(count_left)));
endmodule

// File: tb/sim_byte_copy_engine.sv
module sim_byte_copy_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] src_start = '0, dst_start = '0;
  logic [15:0] count_in = '0;
  logic        wide_mode = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  mem_wdata;
  logic        busy, done;
  logic [31:0] src_ptr, dst_ptr;
  logic [15:0] count_left;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  byte_copy_engine u0 (
    .clk(clk), .rst(rst), .start(start), .src_start(src_start),
    .dst_start(dst_start), .count_in(count_in), .wide_mode(wide_mode),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .busy(busy),
    .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count_left(count_left)
  );

  // memory model: sparse, with a computed default pattern
  logic [7:0] mem [int];

  function automatic logic [7:0] deflt(int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rdm(int a);
    if (mem.exists(a)) return mem[a];
    return deflt(a);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= rdm(int'(mem_addr));
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: queue of expected bus events (0 idle,1 read,2 write,3 done)
  int q[$];
  int ev = 0;
  int e_src = 0, e_dst = 0, e_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      ev = 0; e_src = 0; e_dst = 0; e_cnt = 0;
    end else begin
      if (ev == 2) begin
        e_src = (e_src + 1) & 32'h00FF_FFFF;
        e_dst = (e_dst + 1) & 32'h00FF_FFFF;
        e_cnt = e_cnt - 1;
      end
      if (q.size() > 0) begin
        ev = q.pop_front();
      end else if (ev == 0 && start) begin
        e_src = int'(src_start);
        e_dst = int'(dst_start);
        e_cnt = wide_mode ? int'(count_in) : int'(count_in[7:0]);
        for (int i = 0; i < e_cnt; i++) begin
          q.push_back(1);
          q.push_back(2);
        end
        q.push_back(3);
        ev = q.pop_front();
      end else begin
        ev = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == (ev != 0), "R9 busy", busy, ev != 0);
      chk(done == (ev == 3), "R9 done", done, ev == 3);
      chk(mem_rd == (ev == 1), "R2 mem_rd", mem_rd, ev == 1);
      chk(mem_wr == (ev == 2), "R2 mem_wr", mem_wr, ev == 2);
      if (ev == 1) chk(int'(mem_addr) == e_src, "R2 read addr", mem_addr, e_src);
      if (ev == 2) begin
        chk(int'(mem_addr) == e_dst, "R2 write addr", mem_addr, e_dst);
        chk(mem_wdata == rdm(e_src), "R2 write data", mem_wdata, rdm(e_src));
      end
      chk(src_ptr == 32'(e_src), "R3 src_ptr", src_ptr, e_src);
      chk(dst_ptr == 32'(e_dst), "R3 dst_ptr", dst_ptr, e_dst);
      chk(int'(count_left) == e_cnt, "R4 count_left", count_left, e_cnt);
    end
  end

  task automatic kick(input int s, input int d, input int c, input bit w);
    @(negedge clk);
    src_start = 24'(s); dst_start = 24'(d); count_in = 16'(c); wide_mode = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R9 watchdog waiting for done", 0, 1);
    @(negedge clk);
  endtask

  task automatic check_copy(input string tag, input int s, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      int sa = (s + i) & 32'h00FF_FFFF;
      int da = (d + i) & 32'h00FF_FFFF;
      chk(rdm(da) == deflt(sa), tag, rdm(da), deflt(sa));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_rd && !mem_wr, "R10 flags in reset", {busy, done, mem_rd, mem_wr}, 0);
    chk(src_ptr == 0 && dst_ptr == 0 && count_left == 0, "R10 regs in reset", src_ptr, 0);
    rst = 1'b0;
    @(negedge clk);

    // R6 word mode, 5 bytes
    kick(32'h001000, 32'h002000, 5, 1'b1);
    wait_done();
    check_copy("R4 word copy data", 32'h001000, 32'h002000, 5);
    chk(rdm(32'h002005) == deflt(32'h002005), "R4 no byte past end", rdm(32'h002005), deflt(32'h002005));

    // R1 zero count
    kick(32'h003000, 32'h00A0B0, 0, 1'b1);
    chk(busy && done, "R1 zero count done at once", {busy, done}, 3);
    @(negedge clk);
    chk(!busy && !done, "R1 idle after zero count", {busy, done}, 0);
    chk(rdm(32'h00A0B0) == deflt(32'h00A0B0), "R1 no write on zero", rdm(32'h00A0B0), deflt(32'h00A0B0));

    // R5 byte mode takes low 8 bits: 0x0103 -> 3 bytes
    kick(32'h0100AB, 32'h020000, 16'h0103, 1'b0);
    wait_done();
    check_copy("R5 byte mode data", 32'h0100AB, 32'h020000, 3);
    chk(rdm(32'h020003) == deflt(32'h020003), "R5 only 3 bytes", rdm(32'h020003), deflt(32'h020003));
    chk(count_left == 0, "R5 count zero at end", count_left, 0);

    // R5 byte mode 0x0100 -> nothing
    kick(32'h0300CD, 32'h040000, 16'h0100, 1'b0);
    chk(done, "R5 0x0100 in byte mode is zero", done, 1);
    wait_done();
    chk(rdm(32'h040000) == deflt(32'h040000), "R5 no write for 0x0100", rdm(32'h040000), deflt(32'h040000));

    // R3 wrap at 24 bits
    kick(32'hFFFFFE, 32'h300000, 4, 1'b1);
    wait_done();
    check_copy("R3 wrap copy data", 32'hFFFFFE, 32'h300000, 4);
    chk(src_ptr == 32'h0000_0002, "R3 src wrapped", src_ptr, 32'h2);
    chk(dst_ptr == 32'h0030_0004, "R3 dst end", dst_ptr, 32'h300004);

    // R7 values held while idle
    repeat (5) @(negedge clk);
    chk(src_ptr == 32'h2 && dst_ptr == 32'h300004 && count_left == 0, "R7 final values held", src_ptr, 32'h2);

    // R8 start while busy is ignored
    kick(32'h400000, 32'h410000, 6, 1'b1);
    repeat (3) @(negedge clk);
    src_start = 24'h4000AB; dst_start = 24'h500000; count_in = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_copy("R8 first run intact", 32'h400000, 32'h410000, 6);
    chk(rdm(32'h500000) == deflt(32'h500000), "R8 second start not loaded", rdm(32'h500000), deflt(32'h500000));
    chk(dst_ptr == 32'h410006, "R8 dst end of first run", dst_ptr, 32'h410006);

    // R6 word mode above 255
    kick(32'h600000, 32'h700000, 300, 1'b1);
    wait_done();
    check_copy("R6 word mode 300 bytes", 32'h600000, 32'h700000, 300);
    chk(src_ptr == 32'h60012C, "R6 src end", src_ptr, 32'h60012C);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    bad++;
    total++;
    $display("FAIL R9 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule